// File: doc/BRIEF.md
# Device OUT/SETUP Transaction Responder

This block sits on the device side of a serial bus function. For each OUT or SETUP transaction addressed to one of its endpoints, it decides which handshake to send back. A decoded token arrives first and gives the transaction kind and the endpoint number. The block then waits a bounded time for the data packet. When the end-of-packet strobe arrives, it judges the packet from four things: its PID byte, the CRC-good flag, the buffer-space flag of the endpoint and the halt flag of the endpoint. It then issues an ACK, NAK or STALL request, or no handshake at all.

The block holds one receive toggle bit per endpoint. With these bits it drops a retransmitted packet (acknowledged but not passed on) and keeps every fresh packet. A SETUP packet skips the busy and halt checks, is always taken, and arms the toggle so the next packet is expected as DATA1. A configuration event returns every toggle to DATA0. The accept strobe tells the endpoint buffer to keep the payload it has just received.

Top module: `out_setup_responder`

## Requirements
- R1: An OUT data packet is accepted when all of these hold: its PID byte has the complement nibble `pid[7:4] == ~pid[3:0]`, its PID nibble `pid[3:0]` is DATA0 (`0011`) or DATA1 (`1011`) and matches the endpoint's receive toggle (0 means DATA0), the CRC is good, the endpoint has space and the endpoint is not halted. An accepted packet gets an ACK (`hs_pid = 0010`) with `acc_stb` high for the token's endpoint, and that endpoint's toggle flips.
- R2: A good OUT data packet whose data PID does not match the toggle, on an endpoint that is not halted, gets an ACK. `acc_stb` stays low and the toggle does not change.
- R3: A good OUT data packet that matches the toggle, on an endpoint with no space and not halted, gets a NAK (`1010`). It is not accepted and the toggle does not change.
- R4: An OUT data packet with good CRC to a halted endpoint gets a STALL (`1110`). It is not accepted and the toggle does not change.
- R5: Any of the following produces no handshake, no accept and no toggle change: a bad CRC, a PID byte whose complement nibble is wrong, or a PID that is not DATA0 or DATA1 (for example the ACK byte `D2`).
- R6: A packet is considered only if its end-of-packet strobe is sampled within TIMEOUT_CYC clock edges (one bit time per clock) after the token strobe. A later packet produces no handshake and no toggle change.
- R7: A SETUP followed by a DATA0 packet with good CRC is ACKed and accepted even when the endpoint is halted or has no space. The endpoint's toggle becomes 1 whatever its previous value.
- R8: A SETUP followed by a DATA1 packet, or by a packet with bad CRC, produces no handshake, no accept and no toggle change.
- R9: A pulse on `cfg_event` clears every receive toggle to 0 on the next clock edge.
- R10: `hs_valid` and `acc_stb` are one-cycle pulses registered on the edge that samples the end-of-packet strobe. `acc_ep` carries the token's endpoint, and each endpoint's toggle changes only through its own transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_event | input | 1 | Configuration event; clears all toggles |
| tok_valid | input | 1 | Strobe at the end of a decoded token |
| tok_setup | input | 1 | 1 = SETUP token, 0 = OUT token |
| tok_ep | input | EPW | Endpoint number of the token |
| ep_space | input | NEP | Per-endpoint buffer-space flag |
| ep_halt | input | NEP | Per-endpoint halt flag |
| pkt_eop | input | 1 | End-of-packet strobe of the data packet |
| pkt_pid | input | 8 | Received PID byte (complement nibble above) |
| pkt_crc_ok | input | 1 | CRC-good flag of the data packet |
| hs_valid | output | 1 | Handshake request pulse |
| hs_pid | output | 4 | Handshake PID: ACK 0010, NAK 1010, STALL 1110 |
| acc_stb | output | 1 | Accept-data pulse to the endpoint buffer |
| acc_ep | output | EPW | Endpoint for the accept pulse |
| rx_toggle | output | NEP | Per-endpoint receive toggle |

## Verification
The assertions assume that the end-of-packet strobe and the configuration event are single-cycle pulses. They also assume that each data packet follows its own token, with no second token before the first transaction has ended. The directed stimulus pulses each strobe for exactly one cycle and always lets a transaction end or time out before the next token. It drives `cfg_event` only while no transaction is waiting. The flag inputs change only between transactions, so every decision sees stable endpoint status.

// File: rtl/osr_pkg.sv
package osr_pkg;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;

  typedef enum logic [3:0] {
    HS_NONE  = 4'b0000,
    HS_ACK   = 4'b0010,
    HS_NAK   = 4'b1010,
    HS_STALL = 4'b1110
  } hs_e;

  typedef enum logic [1:0] {
    TOG_KEEP = 2'd0,
    TOG_FLIP = 2'd1,
    TOG_SET1 = 2'd2
  } tog_e;
endpackage

// File: rtl/osr_timer.sv
module osr_timer #(
  parameter int TIMEOUT_CYC = 16,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic active
);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (stop) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/osr_decide.sv
module osr_decide
  import osr_pkg::*;
(
  input  logic       is_setup,
  input  logic [7:0] pid,
  input  logic       crc_ok,
  input  logic       exp_tog,
  input  logic       space,
  input  logic       halt,
  output hs_e        hs,
  output logic       accept,
  output tog_e       tog
);
  logic pid_ok, is_d0, is_d1, is_data;

  always_comb begin
    pid_ok  = (pid[7:4] == ~pid[3:0]);
    is_d0   = (pid[3:0] == PID_DATA0);
    is_d1   = (pid[3:0] == PID_DATA1);
    is_data = pid_ok && (is_d0 || is_d1) && crc_ok;
    hs      = HS_NONE;
    accept  = 1'b0;
    tog     = TOG_KEEP;
    if (is_data) begin
      if (is_setup) begin
        if (is_d0) begin
          hs     = HS_ACK;
          accept = 1'b1;
          tog    = TOG_SET1;
        end
      end else if (halt) begin
        hs = HS_STALL;
      end else if (is_d1 != exp_tog) begin
        hs = HS_ACK;
      end else if (!space) begin
        hs = HS_NAK;
      end else begin
        hs     = HS_ACK;
        accept = 1'b1;
        tog    = TOG_FLIP;
      end
    end
  end
endmodule

// File: rtl/osr_tog_bank.sv
module osr_tog_bank
  import osr_pkg::*;
#(
  parameter int NEP = 4,
  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           we,
  input  logic [EPW-1:0] ep,
  input  tog_e           op,
  output logic [NEP-1:0] tog
);
  for (genvar i = 0; i < NEP; i++) begin : g_ep
    localparam logic [EPW-1:0] IDX = EPW'(i);
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        tog[i] <= 1'b0;
      end else if (we && ep == IDX) begin
        case (op)
          TOG_FLIP: tog[i] <= ~tog[i];
          TOG_SET1: tog[i] <= 1'b1;
          default:  tog[i] <= tog[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/out_setup_responder.sv
module out_setup_responder
  import osr_pkg::*;
#(
  parameter int NEP = 4,
  parameter int TIMEOUT_CYC = 16,
  localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_event,
  input  logic           tok_valid,
  input  logic           tok_setup,
  input  logic [EPW-1:0] tok_ep,
  input  logic [NEP-1:0] ep_space,
  input  logic [NEP-1:0] ep_halt,
  input  logic           pkt_eop,
  input  logic [7:0]     pkt_pid,
  input  logic           pkt_crc_ok,
  output logic           hs_valid,
  output logic [3:0]     hs_pid,
  output logic           acc_stb,
  output logic [EPW-1:0] acc_ep,
  output logic [NEP-1:0] rx_toggle
);
  logic           cur_setup;
  logic [EPW-1:0] cur_ep;
  logic           waiting;
  logic           take;
  hs_e            dec_hs;
  logic           dec_acc;
  tog_e           dec_tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_setup <= 1'b0;
      cur_ep    <= '0;
    end else if (tok_valid) begin
      cur_setup <= tok_setup;
      cur_ep    <= tok_ep;
    end
  end

  osr_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(tok_valid), .stop(take), .active(waiting)
  );

  assign take = pkt_eop && waiting;

  osr_decide u_decide (
    .is_setup(cur_setup), .pid(pkt_pid), .crc_ok(pkt_crc_ok),
    .exp_tog(rx_toggle[cur_ep]), .space(ep_space[cur_ep]),
    .halt(ep_halt[cur_ep]), .hs(dec_hs), .accept(dec_acc), .tog(dec_tog)
  );

  osr_tog_bank #(.NEP(NEP)) u_tog (
    .clk(clk), .rst(rst), .clr(cfg_event), .we(take),
    .ep(cur_ep), .op(dec_tog), .tog(rx_toggle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_pid   <= HS_NONE;
      acc_stb  <= 1'b0;
      acc_ep   <= '0;
    end else begin
      hs_valid <= take && (dec_hs != HS_NONE);
      hs_pid   <= take ? dec_hs : HS_NONE;
      acc_stb  <= take && dec_acc;
      acc_ep   <= cur_ep;
    end
  end
endmodule

// File: rtl/osr_chk.sv
module osr_chk #(
  parameter int NEP = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_event,
  input logic           pkt_eop,
  input logic           hs_valid,
  input logic [3:0]     hs_pid,
  input logic           acc_stb,
  input logic [NEP-1:0] rx_toggle
);
  a_r1_accept_acked: assert property (@(posedge clk) disable iff (rst)
    acc_stb |-> (hs_valid && hs_pid == 4'b0010));

  a_r10_hs_after_eop: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> $past(pkt_eop));

  a_r10_code_legal: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (hs_pid == 4'b0010 || hs_pid == 4'b1010 || hs_pid == 4'b1110));

  a_r9_cfg_clears: assert property (@(posedge clk) disable iff (rst)
    cfg_event |=> (rx_toggle == '0));

  a_r5_toggle_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_toggle) |-> ($past(pkt_eop) || $past(cfg_event)));
endmodule

bind out_setup_responder osr_chk #(.NEP(NEP)) u_chk (.*);

// File: tb/out_setup_responder_bench.sv
module out_setup_responder_bench;
  localparam int NEP = 4;
  localparam int EPW = 2;
  localparam int TO  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_event = 1'b0, tok_valid = 1'b0, tok_setup = 1'b0;
  logic [EPW-1:0] tok_ep = '0;
  logic [NEP-1:0] ep_space = '1, ep_halt = '0;
  logic pkt_eop = 1'b0, pkt_crc_ok = 1'b0;
  logic [7:0] pkt_pid = 8'h00;
  logic hs_valid, acc_stb;
  logic [3:0] hs_pid;
  logic [EPW-1:0] acc_ep;
  logic [NEP-1:0] rx_toggle;

  int checks = 0, failures = 0;
  logic [NEP-1:0] exp_tog = '0;
  logic c_hs, c_acc;
  logic [3:0] c_pid;
  logic [EPW-1:0] c_ep;

  localparam logic [7:0] B_D0 = 8'hC3, B_D1 = 8'h4B;
  localparam logic [3:0] ACK = 4'b0010, NAK = 4'b1010, STL = 4'b1110;

  always #2 clk = ~clk;

  out_setup_responder #(.NEP(NEP), .TIMEOUT_CYC(TO)) u_out_setup_responder (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(bit setup, int ep, logic [7:0] pid, bit crc, int gap);
    @(negedge clk);
    tok_valid = 1'b1; tok_setup = setup; tok_ep = EPW'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
    pkt_pid = pid; pkt_crc_ok = crc; pkt_eop = 1'b1;
    @(negedge clk);
    pkt_eop = 1'b0;
    c_hs = hs_valid; c_pid = hs_pid; c_acc = acc_stb; c_ep = acc_ep;
  endtask

  task automatic expect_hs(string tag, bit ev, logic [3:0] pid, bit acc, int ep);
    check({tag, " hs_valid"}, 32'(c_hs), 32'(ev));
    if (ev) check({tag, " hs_pid"}, 32'(c_pid), 32'(pid));
    check({tag, " acc_stb"}, 32'(c_acc), 32'(acc));
    if (acc) check({tag, " acc_ep"}, 32'(c_ep), 32'(ep));
    check({tag, " rx_toggle"}, 32'(rx_toggle), 32'(exp_tog));
    @(negedge clk);
    check({tag, " pulse ends"}, 32'({hs_valid, acc_stb}), 32'(0));
    repeat (TO + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset hs_valid", 32'(hs_valid), 0);
    check("R10 reset acc_stb", 32'(acc_stb), 0);
    check("R9 reset rx_toggle", 32'(rx_toggle), 0);
  endtask

  task automatic t_accept();
    txn(0, 1, B_D0, 1, 3); exp_tog[1] = 1'b1;
    expect_hs("R1 ep1 DATA0", 1, ACK, 1, 1);
    txn(0, 1, B_D1, 1, 5); exp_tog[1] = 1'b0;
    expect_hs("R1 ep1 DATA1", 1, ACK, 1, 1);
    txn(0, 0, B_D0, 1, 1); exp_tog[0] = 1'b1;
    expect_hs("R10 ep0 independent", 1, ACK, 1, 0);
  endtask

  task automatic t_mismatch();
    txn(0, 0, B_D0, 1, 2);
    expect_hs("R2 repeat dropped", 1, ACK, 0, 0);
  endtask

  task automatic t_nak();
    ep_space[2] = 1'b0;
    txn(0, 2, B_D0, 1, 2);
    expect_hs("R3 busy", 1, NAK, 0, 2);
    ep_space[2] = 1'b1;
  endtask

  task automatic t_stall();
    ep_halt[3] = 1'b1;
    txn(0, 3, B_D0, 1, 2);
    expect_hs("R4 halted", 1, STL, 0, 3);
  endtask

  task automatic t_bad();
    txn(0, 1, B_D0, 0, 2);
    expect_hs("R5 bad crc", 0, 0, 0, 1);
    txn(0, 1, 8'h33, 1, 2);
    expect_hs("R5 bad complement", 0, 0, 0, 1);
    txn(0, 1, 8'hD2, 1, 2);
    expect_hs("R5 non-data pid", 0, 0, 0, 1);
  endtask

  task automatic t_timeout();
    txn(0, 1, B_D0, 1, TO); exp_tog[1] = 1'b1;
    expect_hs("R6 last edge in window", 1, ACK, 1, 1);
    txn(0, 1, B_D1, 1, TO + 1);
    expect_hs("R6 late packet", 0, 0, 0, 1);
  endtask

  task automatic t_setup();
    ep_space[3] = 1'b0;
    txn(1, 3, B_D0, 1, 2); exp_tog[3] = 1'b1;
    expect_hs("R7 setup halted busy", 1, ACK, 1, 3);
    txn(1, 0, B_D0, 1, 2); exp_tog[0] = 1'b1;
    expect_hs("R7 setup forces one", 1, ACK, 1, 0);
    ep_space[3] = 1'b1; ep_halt[3] = 1'b0;
  endtask

  task automatic t_setup_bad();
    txn(1, 2, B_D1, 1, 2);
    expect_hs("R8 setup DATA1", 0, 0, 0, 2);
    txn(1, 2, B_D0, 0, 2);
    expect_hs("R8 setup bad crc", 0, 0, 0, 2);
  endtask

  task automatic t_cfg();
    check("R9 before cfg", 32'(rx_toggle), 32'(exp_tog));
    cfg_event = 1'b1;
    @(negedge clk);
    cfg_event = 1'b0;
    exp_tog = '0;
    check("R9 cfg clears", 32'(rx_toggle), 32'(exp_tog));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_accept();
    t_mismatch();
    t_nak();
    t_stall();
    t_bad();
    t_timeout();
    t_setup();
    t_setup_bad();
    t_cfg();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule